// File: doc/BRIEF.md
# In-Order Integer Pipeline with Opcode-Dependent Operand Stage

The block is a small in-order integer engine that runs a fixed program of register-to-register ADD and SUB operations held in an on-chip ROM. Eight 32-bit registers are preloaded at reset. One start pulse starts the program. Each instruction passes through four stages in turn: fetch, decode/address, operand fetch and execute. The operand-fetch stage holds an instruction for a number of cycles chosen by its opcode. While it is occupied, fetch and decode keep their instructions and execute receives a bubble.

Read-after-write hazards are resolved without waiting for write-back. An instruction entering operand fetch takes its operands from one of three places. The first is the result of the instruction completing operand fetch in that same cycle. The second is the value being written back by execute in that cycle. Otherwise it reads the register file. When the last instruction leaves execute, the block raises a one-cycle completion pulse and reports the cycle count of the run. A registered peek port reads register contents.

Top module: `pipe4_core`

## Requirements
- R1: Every instruction visits fetch, decode, operand fetch and execute in that order, one cycle in each stage except operand fetch. A program whose operand-fetch latencies sum to S therefore takes S + 3 cycles. For the default program ADD R0,R1 ; SUB R2,R0 ; ADD R1,R2 this is 10 cycles.
- R2: Operand fetch holds an instruction for LAT_ADD (default 2) cycles for ADD, LAT_SUB (default 3) cycles for SUB, and 1 cycle for NOP or the reserved opcode.
- R3: ADD d,s writes d+s into d and SUB d,s writes d-s into d. Both are modulo 2^32.
- R4: An instruction word is 16 bits. Bits [15:14] hold the opcode (00 ADD, 01 SUB, 10 reserved, 11 NOP), bits [13:11] the destination register and bits [10:8] the source register. Program entry i sits at bits [16*i+15:16*i] of PROG.
- R5: An operand is taken first from the instruction finishing operand fetch in the same cycle, then from the value execute writes in that cycle, then from the register file.
- R6: While operand fetch still has more than one cycle left, the decode and fetch contents stay unchanged, the remaining count drops by one per cycle, and execute holds no instruction in the next cycle.
- R7: done_o pulses high for exactly one cycle, in the cycle after the last instruction leaves execute. cycle_cnt_o then equals the number of cycles from the first fetch through the last execute and holds that value until the next start.
- R8: A synchronous active-high reset empties the pipeline, clears done_o and cycle_cnt_o, and loads register i with REG_BASE + i*REG_STEP.
- R9: A start pulse while a run is in progress is ignored. A start while idle reruns the program from entry 0 on the current register contents.
- R10: peek_data_o returns the contents of register peek_addr_i one cycle after that address is presented.
- R11: NOP and reserved-opcode instructions change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; begins a run when idle |
| peek_addr_i | input | 3 | Register index to read out |
| done_o | output | 1 | One-cycle completion pulse |
| cycle_cnt_o | output | 16 | Cycle count of the last run |
| peek_data_o | output | 32 | Registered contents of the peeked register |

## Verification
Some cases cannot be reached with the default program. The hardest is the execute write-back forward, which only matters when an operand's producer is two instructions ahead and the instruction between them leaves operand fetch after a single cycle. A second DUT instance therefore runs a six-entry program. In that program a SUB clears R3, a NOP follows, and an ADD then reads R3 in the same cycle that execute writes it. The same program covers a reserved opcode, a self-referencing source and a FO-to-entry forward between back-to-back instructions. A second start is also pulsed in the middle of a run to show that it is ignored.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int IR_W    = 16;
  localparam int OP_LSB  = 14;
  localparam int DST_LSB = 11;
  localparam int SRC_LSB = 8;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_RSV = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  function automatic op_e ir_op(input logic [IR_W-1:0] ir);
    return op_e'(ir[OP_LSB +: 2]);
  endfunction
endpackage

// File: rtl/pipe4_rom.sv
module pipe4_rom #(
  parameter int DEPTH = 3,
  parameter int W     = 16,
  parameter int AW    = 2,
  parameter logic [DEPTH*W-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = IMAGE[g*W +: W];
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
  parameter int DW   = 32,
  parameter int NR   = 8,
  parameter int AW   = 3,
  parameter int BASE = 10,
  parameter int STEP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] pa,
  output logic [DW-1:0] pd
);
  logic [DW-1:0] mem [NR];

  // write-first: a same-cycle reader sees the value being written
  assign rd_a = (we && wa == ra_a) ? wd : mem[ra_a];
  assign rd_b = (we && wa == ra_b) ? wd : mem[ra_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) mem[i] <= DW'(BASE + i * STEP);
    end else if (we) begin
      mem[wa] <= wd;
    end
    pd <= mem[pa];
  end
endmodule

// File: rtl/pipe4_alu.sv
module pipe4_alu
  import pipe4_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          wr
);
  always_comb begin
    unique case (op)
      OP_ADD:  begin y = a + b; wr = 1'b1; end
      OP_SUB:  begin y = a - b; wr = 1'b1; end
      default: begin y = a;     wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NREG     = 8,
  parameter int CNT_W    = 16,
  parameter int LAT_ADD  = 2,
  parameter int LAT_SUB  = 3,
  parameter int REG_BASE = 10,
  parameter int REG_STEP = 5,
  parameter int PROG_LEN = 3,
  parameter logic [PROG_LEN*16-1:0] PROG = {16'h0A00, 16'h5000, 16'h0100}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [$clog2(NREG)-1:0]  peek_addr_i,
  output logic                     done_o,
  output logic [CNT_W-1:0]         cycle_cnt_o,
  output logic [DW-1:0]            peek_data_o
);
  localparam int REG_AW = $clog2(NREG);
  localparam int PC_W   = $clog2(PROG_LEN + 1);
  localparam int LAT_MX = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
  localparam int LAT_W  = $clog2(LAT_MX + 1);

  logic              running;
  logic [PC_W-1:0]   pc;
  logic              if_v, if_last;
  logic [IR_W-1:0]   if_ir;
  logic              da_v, da_last;
  logic [IR_W-1:0]   da_ir;
  logic              fo_v, fo_last;
  op_e               fo_op;
  logic [REG_AW-1:0] fo_dst;
  logic [LAT_W-1:0]  fo_cnt;
  logic [DW-1:0]     fo_a, fo_b;
  logic              ex_v, ex_we, ex_last;
  logic [REG_AW-1:0] ex_dst;
  logic [DW-1:0]     ex_res;

  logic              fo_fin, adv, launch, fetch;
  logic [PC_W-1:0]   rom_addr;
  op_e               da_op;
  logic [REG_AW-1:0] da_dst, da_src;
  logic [LAT_W-1:0]  da_lat;
  logic [DW-1:0]     rd_a, rd_b, opa, opb, fo_res;
  logic              fo_wr_op, fo_fwd;

  assign fo_fin   = fo_v && (fo_cnt == LAT_W'(1));
  assign adv      = !fo_v || fo_fin;
  assign launch   = start_i && !running;
  assign fetch    = launch || (running && adv && (pc < PC_W'(PROG_LEN)));
  assign rom_addr = launch ? '0 : pc;

  assign da_op  = ir_op(da_ir);
  assign da_dst = da_ir[DST_LSB +: REG_AW];
  assign da_src = da_ir[SRC_LSB +: REG_AW];

  always_comb begin
    unique case (da_op)
      OP_ADD:  da_lat = LAT_W'(LAT_ADD);
      OP_SUB:  da_lat = LAT_W'(LAT_SUB);
      default: da_lat = LAT_W'(1);
    endcase
  end

  pipe4_rom #(.DEPTH(PROG_LEN), .W(IR_W), .AW(PC_W), .IMAGE(PROG)) u_rom (
    .clk(clk), .en(fetch), .addr(rom_addr), .q(if_ir)
  );

  pipe4_regfile #(.DW(DW), .NR(NREG), .AW(REG_AW), .BASE(REG_BASE), .STEP(REG_STEP)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(da_dst), .rd_a(rd_a), .ra_b(da_src), .rd_b(rd_b),
    .we(ex_we), .wa(ex_dst), .wd(ex_res),
    .pa(peek_addr_i), .pd(peek_data_o)
  );

  pipe4_alu #(.DW(DW)) u_alu (
    .op(fo_op), .a(fo_a), .b(fo_b), .y(fo_res), .wr(fo_wr_op)
  );

  // forward from the instruction leaving operand fetch this cycle
  assign fo_fwd = fo_fin && fo_wr_op;
  assign opa    = (fo_fwd && fo_dst == da_dst) ? fo_res : rd_a;
  assign opb    = (fo_fwd && fo_dst == da_src) ? fo_res : rd_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      pc          <= '0;
      if_v        <= 1'b0;
      if_last     <= 1'b0;
      da_v        <= 1'b0;
      da_last     <= 1'b0;
      fo_v        <= 1'b0;
      fo_last     <= 1'b0;
      fo_cnt      <= '0;
      ex_v        <= 1'b0;
      ex_we       <= 1'b0;
      ex_last     <= 1'b0;
      done_o      <= 1'b0;
      cycle_cnt_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (fetch) if_last <= (rom_addr == PC_W'(PROG_LEN - 1));

      if (launch) begin
        running     <= 1'b1;
        pc          <= PC_W'(1);
        if_v        <= 1'b1;
        cycle_cnt_o <= CNT_W'(1);
      end else if (running) begin
        if (ex_v && ex_last) begin
          running <= 1'b0;
          done_o  <= 1'b1;
        end else begin
          cycle_cnt_o <= cycle_cnt_o + 1'b1;
        end
        if (adv) begin
          if_v <= fetch;
          if (fetch) pc <= pc + 1'b1;
        end
      end

      if (adv) begin
        da_v    <= if_v;
        da_ir   <= if_ir;
        da_last <= if_last;
        fo_v    <= da_v;
        fo_op   <= da_op;
        fo_dst  <= da_dst;
        fo_cnt  <= da_v ? da_lat : '0;
        fo_a    <= opa;
        fo_b    <= opb;
        fo_last <= da_last;
      end else if (fo_v) begin
        fo_cnt <= fo_cnt - 1'b1;
      end

      ex_v    <= fo_fin;
      ex_we   <= fo_fwd;
      ex_last <= fo_fin && fo_last;
      ex_dst  <= fo_dst;
      ex_res  <= fo_res;
    end
  end
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk #(
  parameter int CW = 16,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          done_o,
  input logic [CW-1:0] cycle_cnt_o,
  input logic          fo_v,
  input logic [LW-1:0] fo_cnt,
  input logic          da_v,
  input logic [15:0]   da_ir,
  input logic          ex_v
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_cnt_mono_r7: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> cycle_cnt_o >= $past(cycle_cnt_o));

  p_hold_front_r6: assert property (@(posedge clk) disable iff (rst)
    (fo_v && fo_cnt > LW'(1)) |=> ($stable(da_v) && $stable(da_ir)));

  p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (fo_v && fo_cnt > LW'(1)) |=> !ex_v);

  p_countdown_r2: assert property (@(posedge clk) disable iff (rst)
    (fo_v && fo_cnt > LW'(1)) |=> (fo_v && fo_cnt == $past(fo_cnt) - 1'b1));
endmodule

bind pipe4_core pipe4_core_chk #(.CW(CNT_W), .LW(LAT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .cycle_cnt_o(cycle_cnt_o), .fo_v(fo_v), .fo_cnt(fo_cnt),
  .da_v(da_v), .da_ir(da_ir), .ex_v(ex_v)
);

// File: tb/pipe4_core_tb.sv
`timescale 1ns/1ps
module pipe4_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_a = 1'b0, start_b = 1'b0;
  logic [2:0]  peek_a = '0, peek_b = '0;
  logic        done_a, done_b;
  logic [15:0] cnt_a, cnt_b;
  logic [31:0] data_a, data_b;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // default program, registers start at 10 + 5*i
  pipe4_core u_dut (
    .clk(clk), .rst(rst), .start_i(start_a), .peek_addr_i(peek_a),
    .done_o(done_a), .cycle_cnt_o(cnt_a), .peek_data_o(data_a)
  );

  // SUB R3,R3 ; NOP ; ADD R4,R3 ; reserved R5,R5 ; ADD R7,R7 ; SUB R6,R7
  // registers start at 100 + 7*i; FO latencies 3,1,2,1,2,3 -> 12 + 3 = 15
  pipe4_core #(.REG_BASE(100), .REG_STEP(7), .PROG_LEN(6),
               .PROG({16'h7700, 16'h3F00, 16'hAD00, 16'h2300, 16'hC000, 16'h5B00}))
  u_alt (
    .clk(clk), .rst(rst), .start_i(start_b), .peek_addr_i(peek_b),
    .done_o(done_b), .cycle_cnt_o(cnt_b), .peek_data_o(data_b)
  );

  localparam logic [31:0] ALT_EXP [8] = '{
    32'd100, 32'd107, 32'd114, 32'd0, 32'd128, 32'd135, 32'hFFFFFF64, 32'd298
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek_dut(input logic [2:0] a, output logic [31:0] d);
    peek_a = a;
    @(negedge clk);
    d = data_a;
  endtask

  // pulse start, return cycles from start edge to the negedge where done is seen
  task automatic run_dut(input bit extra_start, output int n);
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    n = 1;
    while (!done_a && n < 300) begin
      @(negedge clk);
      n++;
      if (extra_start && n == 4) start_a = 1'b1;
      else start_a = 1'b0;
    end
  endtask

  initial begin
    int n;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(done_a == 1'b0, "R8 done after reset", 32'(done_a), 32'd0);
    chk(cnt_a == 16'd0, "R8 count after reset", 32'(cnt_a), 32'd0);
    peek_dut(3'd0, d); chk(d == 32'd10, "R8/R10 init R0", d, 32'd10);
    peek_dut(3'd2, d); chk(d == 32'd20, "R8/R10 init R2", d, 32'd20);

    // R1 R3 R5: default program
    run_dut(1'b0, n);
    chk(n == 11, "R1 done timing", 32'(n), 32'd11);
    chk(cnt_a == 16'd10, "R1/R7 cycle count", 32'(cnt_a), 32'd10);
    @(negedge clk);
    chk(done_a == 1'b0, "R7 done one cycle", 32'(done_a), 32'd0);
    chk(cnt_a == 16'd10, "R7 count held", 32'(cnt_a), 32'd10);
    peek_dut(3'd0, d); chk(d == 32'd25, "R3 ADD R0", d, 32'd25);
    peek_dut(3'd2, d); chk(d == 32'hFFFFFFFB, "R5 SUB R2 forwarded", d, 32'hFFFFFFFB);
    peek_dut(3'd1, d); chk(d == 32'd10, "R5 ADD R1 forwarded", d, 32'd10);
    peek_dut(3'd3, d); chk(d == 32'd25, "R3 R3 untouched", d, 32'd25);

    // R9: rerun on current contents, with a start mid-run that must be ignored
    run_dut(1'b1, n);
    chk(n == 11, "R9 ignored start timing", 32'(n), 32'd11);
    chk(cnt_a == 16'd10, "R9 count", 32'(cnt_a), 32'd10);
    peek_dut(3'd0, d); chk(d == 32'd35, "R9 rerun R0", d, 32'd35);
    peek_dut(3'd2, d); chk(d == 32'hFFFFFFD8, "R9 rerun R2", d, 32'hFFFFFFD8);
    peek_dut(3'd1, d); chk(d == 32'hFFFFFFE2, "R9 rerun R1", d, 32'hFFFFFFE2);

    // R2 R4 R11 R5: alternate program
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    n = 1;
    while (!done_b && n < 300) begin @(negedge clk); n++; end
    chk(n == 16, "R2 alt done timing", 32'(n), 32'd16);
    chk(cnt_b == 16'd15, "R2 alt latency sum", 32'(cnt_b), 32'd15);
    for (int i = 0; i < 8; i++) begin
      peek_b = 3'(i);
      @(negedge clk);
      chk(data_b == ALT_EXP[i], $sformatf("R4/R11/R5 alt reg %0d", i), data_b, ALT_EXP[i]);
    end

    // R8: reset restores initial registers and clears the count
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cnt_a == 16'd0, "R8 count cleared", 32'(cnt_a), 32'd0);
    peek_dut(3'd1, d); chk(d == 32'd15, "R8 R1 reloaded", d, 32'd15);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule